// File: doc/BRIEF.md
# Page Write Load Controller

This controller sits inside a behavioural model of a byte-wide nonvolatile memory. It watches the host strobes (active-low chip enable, output enable and write enable) on a system clock. Each qualified write pulse becomes one byte write into a 64-byte page buffer. The upper address bits fix the page, and the lower six bits pick the byte within it.

The first accepted byte opens a load window. Every further byte for the same page restarts an inter-byte timer. When the timer expires, loading closes and one programming period starts. A per-byte valid mask tells the memory array which locations to program. Busy stays high until the period ends. All timing limits are parameters counted in clock cycles.

Top module: `pgwr_ctrl`

## Requirements
- R1: A write to address `addr` lands in page `addr[14:6]` at byte index `addr[5:0]`. `buf_idx` shows the byte index and `page_addr` shows the page of the open load.
- R2: A write pulse counts only if it lasts at least `MIN_PULSE` consecutive clock cycles. A shorter pulse changes neither the buffer port nor the mask.
- R3: A clock cycle belongs to a write pulse only while `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold. A cycle with `oe_n` low or with only one of `ce_n`/`we_n` low writes nothing.
- R4: The address is taken from the first cycle in which both `ce_n` and `we_n` are low. The data is taken from the last cycle before either of them returns high.
- R5: For `LOCK_CYC` cycles after reset every write is refused.
- R6: The first accepted byte opens a load window and leaves `busy` low. Once `BLC_CYC` cycles pass with no accepted byte, `commit` pulses and `busy` rises.
- R7: A write that carries a different page while the load window is open is ignored and does not restart the timer.
- R8: Bytes may arrive in any order. A byte written twice in one window keeps its mask bit, and the second value appears on `buf_data`.
- R9: While `busy` is high, `valid_mask` holds exactly the bits of the byte indices loaded in that window (bit n = index n).
- R10: `busy` stays high for `PROG_CYC` cycles. `prog_done` then pulses, and `busy` and `valid_mask` return to zero.
- R11: Writes received while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | 15 | Host byte address |
| din | input | 8 | Host write data |
| buf_we | output | 1 | Page buffer write strobe |
| buf_idx | output | 6 | Page buffer byte index |
| buf_data | output | 8 | Page buffer write data |
| valid_mask | output | 64 | Loaded-byte mask for the current page |
| page_addr | output | 9 | Page number of the current load |
| busy | output | 1 | Programming in progress |
| commit | output | 1 | One-cycle pulse when loading closes |
| prog_done | output | 1 | One-cycle pulse when programming ends |

## Verification
The assertions assume the strobes are already synchronous to `clk` and take one value per cycle. The bench drives every pin on the falling clock edge, so each rising edge sees stable levels.

The assertions also assume that `addr` and `din` matter only inside a qualified pulse. The stimulus changes them mid-pulse only in the capture test, and there on purpose.

The bench gaps between bytes are kept far from the timeout. Every expected timeout is sampled well after expiry, so the result does not rest on a single cycle.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int ADDR_W     = 15;
  localparam int DATA_W     = 8;
  localparam int OFS_W      = 6;
  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int PAGE_BYTES = 1 << OFS_W;

  typedef enum logic [1:0] {W_IDLE, W_LOAD, W_PROG} wst_e;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  function automatic logic [PAGE_BYTES-1:0] ofs_bit(input logic [OFS_W-1:0] o);
    return PAGE_BYTES'(1) << o;
  endfunction
endpackage

// File: rtl/pgwr_strobe.sv
module pgwr_strobe
  import pgwr_pkg::*;
#(
  parameter int MIN_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              acc_v,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data
);
  localparam int LEN_W = $clog2(MIN_PULSE + 1);

  logic              act, act_r, pulse_end;
  logic [LEN_W-1:0]  len;
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] data_r;

  // R3: qualified write cycle needs both enables low and output enable high
  assign act       = !ce_n && !we_n && oe_n;
  assign pulse_end = act_r && !act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_r    <= 1'b0;
      len      <= '0;
      addr_r   <= '0;
      data_r   <= '0;
      acc_v    <= 1'b0;
      acc_addr <= '0;
      acc_data <= '0;
    end else begin
      act_r <= act;
      if (act) begin
        if (!act_r) begin
          len    <= LEN_W'(1);
          addr_r <= addr;       // R4: address at the later falling edge
        end else if (len != LEN_W'(MIN_PULSE)) begin
          len <= len + LEN_W'(1);
        end
        data_r <= din;          // R4: last active cycle wins
      end
      acc_v    <= pulse_end && (len >= LEN_W'(MIN_PULSE));  // R2
      acc_addr <= addr_r;
      acc_data <= data_r;
    end
  end

  a_r3_accept_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    acc_v |-> ($past(act_r) && !$past(act)));
endmodule

// File: rtl/pgwr_lockout.sv
module pgwr_lockout #(
  parameter int LOCK_CYC = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);
  logic [CNT_W-1:0] cnt;

  assign locked = (cnt != CNT_W'(LOCK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (locked) cnt <= cnt + CNT_W'(1);
  end

  a_r5_lock_releases_once: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !locked);
endmodule

// File: rtl/pgwr_window.sv
module pgwr_window
  import pgwr_pkg::*;
#(
  parameter int BLC_CYC  = 30000,
  parameter int PROG_CYC = 2000000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  locked,
  input  logic                  acc_v,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [DATA_W-1:0]     acc_data,
  output logic                  buf_we,
  output logic [OFS_W-1:0]      buf_idx,
  output logic [DATA_W-1:0]     buf_data,
  output logic [PAGE_BYTES-1:0] valid_mask,
  output logic [PAGE_W-1:0]     page_addr,
  output logic                  busy,
  output logic                  commit,
  output logic                  prog_done
);
  localparam int TMR_W = $clog2(BLC_CYC + 1);
  localparam int PRG_W = $clog2(PROG_CYC + 1);

  wst_e              st;
  logic [TMR_W-1:0]  tmr;
  logic [PRG_W-1:0]  pcnt;
  logic [PAGE_W-1:0] page_q;
  logic              same_page, take, in_load;

  assign in_load   = (st == W_LOAD);
  assign same_page = (page_of(acc_addr) == page_q);
  // R5, R7, R11: a byte is taken only when unlocked, idle or same page, not busy
  assign take      = acc_v && !locked && ((st == W_IDLE) || (in_load && same_page));
  assign commit    = in_load && !take && (tmr == TMR_W'(BLC_CYC - 1));
  assign prog_done = (st == W_PROG) && (pcnt == PRG_W'(PROG_CYC - 1));

  assign buf_we    = take;
  assign buf_idx   = ofs_of(acc_addr);
  assign buf_data  = acc_data;
  assign page_addr = page_q;
  assign busy      = (st == W_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      tmr        <= '0;
      pcnt       <= '0;
      page_q     <= '0;
      valid_mask <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (take) begin
          st         <= W_LOAD;
          page_q     <= page_of(acc_addr);
          valid_mask <= ofs_bit(ofs_of(acc_addr));
          tmr        <= '0;
        end
        W_LOAD: begin
          if (take) begin
            valid_mask <= valid_mask | ofs_bit(ofs_of(acc_addr));
            tmr        <= '0;
          end else if (commit) begin
            st   <= W_PROG;
            pcnt <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: begin
          if (prog_done) begin
            st         <= W_IDLE;
            valid_mask <= '0;
          end else begin
            pcnt <= pcnt + TMR_W'(0) + PRG_W'(1);
          end
        end
      endcase
    end
  end

  a_r10_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (!busy && valid_mask == '0));
  a_r11_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we);
  a_r5_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !buf_we);
  a_r9_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> $stable(valid_mask));
  a_r8_mask_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && !commit) |=> ((valid_mask & $past(valid_mask)) == $past(valid_mask)));
  a_r7_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |=> (!in_load || $stable(page_q)));
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int MIN_PULSE = 3,
  parameter int BLC_CYC   = 30000,
  parameter int PROG_CYC  = 2000000,
  parameter int LOCK_CYC  = 2000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [14:0] addr,
  input  logic [7:0]  din,
  output logic        buf_we,
  output logic [5:0]  buf_idx,
  output logic [7:0]  buf_data,
  output logic [63:0] valid_mask,
  output logic [8:0]  page_addr,
  output logic        busy,
  output logic        commit,
  output logic        prog_done
);
  logic              acc_v, locked;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_data;

  pgwr_strobe #(.MIN_PULSE(MIN_PULSE)) u_strobe (
    .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .din,
    .acc_v, .acc_addr, .acc_data
  );

  pgwr_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk, .rst_n, .locked
  );

  pgwr_window #(.BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC)) u_win (
    .clk, .rst_n, .locked, .acc_v, .acc_addr, .acc_data,
    .buf_we, .buf_idx, .buf_data, .valid_mask, .page_addr,
    .busy, .commit, .prog_done
  );
endmodule

// File: tb/tb_pgwr_ctrl.sv
`timescale 1ns/1ps
module tb_pgwr_ctrl;
  localparam int MINP = 3, BLC = 40, PRG = 60, LCK = 30;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic buf_we, busy, commit, prog_done;
  logic [5:0]  buf_idx;
  logic [7:0]  buf_data;
  logic [63:0] valid_mask;
  logic [8:0]  page_addr;

  int errors = 0, checks = 0, wr_cnt = 0, cm_cnt = 0, dn_cnt = 0;
  logic [5:0] last_idx;
  logic [7:0] last_data;
  logic [63:0] cm_mask;

  always #2.5 clk = ~clk;

  pgwr_ctrl #(.MIN_PULSE(MINP), .BLC_CYC(BLC), .PROG_CYC(PRG), .LOCK_CYC(LCK)) dut (
    .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .din,
    .buf_we, .buf_idx, .buf_data, .valid_mask, .page_addr,
    .busy, .commit, .prog_done
  );

  always @(negedge clk) begin
    if (buf_we) begin wr_cnt++; last_idx = buf_idx; last_data = buf_data; end
    if (commit) begin cm_cnt++; cm_mask = valid_mask; end
    if (prog_done) dn_cnt++;
  end

  function automatic logic [14:0] mk(input int pg, input int ofs);
    return {9'(pg), 6'(ofs)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input int len);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    cyc(len);
    ce_n = 1; we_n = 1;
    cyc(3);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", 64'(busy), 0);
    chk("R9 reset mask", valid_mask, 0);
  endtask

  task automatic t_lockout();
    wr(mk(2, 4), 8'h11, 5);
    chk("R5 no write while locked", 64'(wr_cnt), 0);
    chk("R5 mask empty while locked", valid_mask, 0);
    cyc(LCK + 5);
  endtask

  task automatic t_short_pulse();
    wr(mk(1, 7), 8'h22, MINP - 1);
    chk("R2 short pulse rejected", 64'(wr_cnt), 0);
    chk("R2 short pulse mask", valid_mask, 0);
    wr(mk(1, 7), 8'h23, MINP);
    chk("R2 minimum pulse accepted", valid_mask, 64'(1) << 7);
    chk("R1 page number", 64'(page_addr), 1);
    cyc(BLC + PRG + 10);
  endtask

  task automatic t_inhibit();
    int w0 = wr_cnt;
    @(negedge clk); addr = mk(5, 1); din = 8'h33; ce_n = 0; we_n = 0; oe_n = 0;
    cyc(5); ce_n = 1; we_n = 1; oe_n = 1; cyc(3);
    chk("R3 oe low inhibits", 64'(wr_cnt - w0), 0);
    @(negedge clk); we_n = 0; cyc(5); we_n = 1; cyc(3);
    chk("R3 ce high inhibits", 64'(wr_cnt - w0), 0);
    @(negedge clk); ce_n = 0; cyc(5); ce_n = 1; cyc(3);
    chk("R3 we high inhibits", 64'(wr_cnt - w0), 0);
    chk("R3 mask untouched", valid_mask, 0);
  endtask

  task automatic t_page_load();
    int t0, d0;
    logic [63:0] em;
    em = (64'(1) << 5) | 64'(1) | (64'(1) << 63);
    wr(mk(9'h15, 5), 8'hA0, 4);
    wr(mk(9'h15, 0), 8'hA1, 4);
    wr(mk(9'h15, 63), 8'hA2, 4);
    wr(mk(9'h15, 5), 8'hB5, 4);
    chk("R8 reload index", 64'(last_idx), 5);
    chk("R8 reload data replaces", 64'(last_data), 8'hB5);
    chk("R8 any order mask", valid_mask, em);
    chk("R1 page of load", 64'(page_addr), 9'h15);
    cyc(BLC / 2);
    chk("R6 still loading before timeout", 64'(busy), 0);
    t0 = 0;
    while (!busy && t0 < BLC + 5) begin cyc(1); t0++; end
    chk("R6 busy after timeout", 64'(busy), 1);
    chk("R6 one commit pulse", 64'(cm_cnt), 2);
    chk("R9 mask at commit", cm_mask, em);
    d0 = dn_cnt;
    cyc(PRG - 2);
    chk("R10 busy through programming", 64'(busy), 1);
    chk("R9 mask held while busy", valid_mask, em);
    cyc(3);
    chk("R10 busy released", 64'(busy), 0);
    chk("R10 done pulse", 64'(dn_cnt - d0), 1);
    chk("R10 mask cleared", valid_mask, 0);
  endtask

  task automatic t_other_page_busy();
    int w0;
    wr(mk(3, 1), 8'h41, 4);
    cyc(20);
    w0 = wr_cnt;
    wr(mk(4, 2), 8'h42, 4);
    chk("R7 foreign page ignored", 64'(wr_cnt - w0), 0);
    cyc(20);
    chk("R7 timer not restarted", 64'(busy), 1);
    chk("R7 mask only own page", valid_mask, 64'(1) << 1);
    w0 = wr_cnt;
    wr(mk(3, 9), 8'h43, 4);
    chk("R11 write ignored while busy", 64'(wr_cnt - w0), 0);
    chk("R11 mask unchanged while busy", valid_mask, 64'(1) << 1);
    cyc(PRG + 5);
  endtask

  task automatic t_capture();
    @(negedge clk); addr = mk(6, 30); din = 8'hEE; ce_n = 0;
    cyc(2); addr = mk(6, 12); we_n = 0;
    cyc(1); addr = mk(6, 40); din = 8'h01;
    cyc(1); din = 8'h02;
    cyc(1); din = 8'h5C;
    cyc(1); ce_n = 1; we_n = 1; din = 8'hFF;
    cyc(3);
    chk("R4 address at later falling edge", 64'(last_idx), 12);
    chk("R4 data from last active cycle", 64'(last_data), 8'h5C);
    chk("R1 mask bit of byte index", valid_mask, 64'(1) << 12);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_lockout();
    t_short_pulse();
    t_inhibit();
    t_page_load();
    t_other_page_busy();
    t_capture();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule